// File: doc/BRIEF.md
# Audio Port Status and Interrupt Controller

This block is the control and status word of one direction (transmit or receive) of a serial audio port. A single 32-bit register holds five interrupt enables and five matching status flags, a FIFO watermark threshold, a request enable for the FIFO transfer request, a FIFO-clear command, a soft-reset bit and the port enable. The datapath feeds it one-cycle event strobes (word start, frame sync error, FIFO underrun/overflow), a live FIFO warning level (empty on transmit, full on receive) and the FIFO fill level. The block turns these into flags, one interrupt line and one gated transfer request.

Three flags are sticky and are cleared by writing one. The warning and watermark flags track the FIFO live and ignore writes. A disable request does not stop the port at once: the enable readback stays one until the datapath reports the end of the current frame. Software reads and writes the whole word through a plain write strobe and an always-valid read bus. To change one field it must write back the other fields as well.

Top module: `aud_port_csr`

## Requirements
- R1: The interrupt enables sit in bits 4:0 and the flags in bits 20:16, so each flag is its enable bit shifted up by 16. Bit order within each field is word start (0), sync error (1), FIFO error (2), FIFO warning (3), watermark (4). The enables read back as written, and every bit that no requirement names reads zero.
- R2: A strobe on ev_word_start, ev_sync_err or ev_fifo_err sets its flag on the next clock edge. The flag stays set until a write with a one in its flag bit clears it. Writing zero to a flag bit has no effect.
- R3: If a sticky event and a clearing write for the same flag arrive in the same cycle, the flag stays set.
- R4: The warning flag (bit 19) shows the value fifo_warn had in the previous cycle. Writes to bit 19 are ignored.
- R5: The threshold field sits in bits 9 upward and is LVL_W bits wide. The watermark flag (bit 20) is updated one cycle after the level and threshold change. It is set when fifo_level <= threshold on a transmit instance and when fifo_level > threshold on a receive instance. Writes to bit 20 are ignored.
- R6: Writing one to bit 24 produces a one-cycle fifo_clr pulse on the following cycle. Bit 24 always reads zero.
- R7: Bit 25 is the soft-reset bit and reads back as written. xfer_rst follows it. From the cycle after it reads one, and for as long as it stays one, the sticky flags and the port enable are held at zero. The enables, the threshold and the request enable are kept.
- R8: Writing one to bit 31 sets port_en and the bit-31 readback on the next cycle. After a write of zero, both stay one until a frame_end strobe, and they read zero on the cycle after it. A frame_end that arrives in the same cycle as the write of zero ends the port at once.
- R9: Bit 8 is the request enable. dma_req equals the watermark flag ANDed with this bit, in the same cycle as the flag. Clearing bit 8 does not change the port enable.
- R10: irq is high exactly when the bitwise AND of the flag field and the enable field is non-zero, and it changes in the same cycle as the flags.
- R11: After the synchronous reset, the register reads zero and irq, dma_req, fifo_clr, xfer_rst and port_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| ev_word_start | input | 1 | Word-start event strobe |
| ev_sync_err | input | 1 | Frame sync error strobe |
| ev_fifo_err | input | 1 | FIFO underrun (transmit) or overflow (receive) strobe |
| fifo_warn | input | 1 | Live FIFO empty (transmit) or full (receive) indication |
| fifo_level | input | LVL_W | FIFO fill level |
| frame_end | input | 1 | End of the current frame strobe |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Gated FIFO transfer request |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| xfer_rst | output | 1 | Hold the transfer logic in reset |
| port_en | output | 1 | Port enable as seen by the datapath |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. This applies to flags, enables, readback fields, irq, dma_req, the fifo_clr pulse, xfer_rst and port_en. A change of bit 31 after a disable request is due one edge after the frame_end strobe. The effect of the soft-reset bit on the other fields starts one edge after the bit itself reads one. The bench drives its inputs just after a rising edge. A behavioural model updates at the same edge from the same inputs, and every output field is compared at the falling edge, so each check looks at the cycle in which the result is due. The directed phases cover the collision of an event with a clear, writes to the live flags, a disable before and during frame_end, and a soft reset with events pending. A receive instance is checked against the opposite watermark comparison.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int NFLAG    = 5;
  localparam int NSTICKY  = 3;
  localparam int F_WSTART = 0;
  localparam int F_SYNC   = 1;
  localparam int F_FERR   = 2;
  localparam int F_WARN   = 3;
  localparam int F_WMARK  = 4;
  localparam int IEN_LSB  = 0;
  localparam int FLAG_LSB = 16;
  localparam int REQ_BIT  = 8;
  localparam int THR_LSB  = 9;
  localparam int FRST_BIT = 24;
  localparam int SRST_BIT = 25;
  localparam int PEN_BIT  = 31;
endpackage

// File: rtl/aps_flags.sv
module aps_flags
  import aps_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter bit IS_TX = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [NFLAG-1:0]   wr_ones,
  input  logic               sr_q,
  input  logic [NSTICKY-1:0] ev,
  input  logic               fifo_warn,
  input  logic [LVL_W-1:0]   level,
  input  logic [LVL_W-1:0]   thresh,
  output logic [NFLAG-1:0]   flags_d,
  output logic [NFLAG-1:0]   flags_q
);
  genvar i;
  generate
    for (i = 0; i < NSTICKY; i++) begin : g_sticky
      // event has priority over a write-one clear
      assign flags_d[i] = sr_q ? 1'b0 : (ev[i] | (flags_q[i] & ~(wr & wr_ones[i])));

      assert_sticky_set_R2 : assert property (@(posedge clk) disable iff (rst)
        (!sr_q && ev[i]) |=> flags_q[i]);
      assert_sticky_keep_R3 : assert property (@(posedge clk) disable iff (rst)
        (!sr_q && flags_q[i] && !(wr && wr_ones[i])) |=> flags_q[i]);
    end
  endgenerate

  assign flags_d[F_WARN] = fifo_warn;

  generate
    if (IS_TX) begin : g_tx_wm
      assign flags_d[F_WMARK] = (level <= thresh);
    end else begin : g_rx_wm
      assign flags_d[F_WMARK] = (level > thresh);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assert_warn_live_R4 : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_q[F_WARN] == $past(fifo_warn)));
endmodule

// File: rtl/aps_port_en.sv
module aps_port_en (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_en_bit,
  input  logic sr_q,
  input  logic frame_end,
  output logic active_q
);
  logic en_req_q, en_req_d, active_d;

  always_comb begin
    en_req_d = en_req_q;
    active_d = active_q;
    if (sr_q) begin
      en_req_d = 1'b0;
      active_d = 1'b0;
    end else begin
      if (wr) en_req_d = wr_en_bit;
      if (wr && wr_en_bit)            active_d = 1'b1;
      else if (frame_end && !en_req_d) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_req_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      en_req_q <= en_req_d;
      active_q <= active_d;
    end
  end

  assert_hold_to_frame_R8 : assert property (@(posedge clk) disable iff (rst)
    (!sr_q && active_q && !frame_end) |=> active_q);
  assert_drop_at_frame_R8 : assert property (@(posedge clk) disable iff (rst)
    (!sr_q && !wr && !en_req_q && frame_end) |=> !active_q);
endmodule

// File: rtl/aps_irq_out.sv
module aps_irq_out
  import aps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags_d,
  input  logic [NFLAG-1:0] ien_d,
  input  logic             req_en_d,
  output logic             irq,
  output logic             dma_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq     <= |(flags_d & ien_d);
      dma_req <= flags_d[F_WMARK] & req_en_d;
    end
  end
endmodule

// File: rtl/aud_port_csr.sv
module aud_port_csr
  import aps_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter bit IS_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_word_start,
  input  logic             ev_sync_err,
  input  logic             ev_fifo_err,
  input  logic             fifo_warn,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             frame_end,
  output logic             irq,
  output logic             dma_req,
  output logic             fifo_clr,
  output logic             xfer_rst,
  output logic             port_en
);
  localparam int THR_MSB = THR_LSB + LVL_W - 1;

  logic [NFLAG-1:0] ien_q, ien_d, flags_d, flags_q;
  logic [LVL_W-1:0] thr_q;
  logic             req_q, req_d, sr_q, fclr_q, active_q;

  assign ien_d = reg_wr ? reg_wdata[IEN_LSB +: NFLAG] : ien_q;
  assign req_d = reg_wr ? reg_wdata[REQ_BIT] : req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      req_q  <= 1'b0;
      thr_q  <= '0;
      sr_q   <= 1'b0;
      fclr_q <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      req_q  <= req_d;
      fclr_q <= reg_wr & reg_wdata[FRST_BIT];
      if (reg_wr) begin
        thr_q <= reg_wdata[THR_MSB:THR_LSB];
        sr_q  <= reg_wdata[SRST_BIT];
      end
    end
  end

  aps_flags #(.LVL_W(LVL_W), .IS_TX(IS_TX)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .wr_ones   (reg_wdata[FLAG_LSB +: NFLAG]),
    .sr_q      (sr_q),
    .ev        ({ev_fifo_err, ev_sync_err, ev_word_start}),
    .fifo_warn (fifo_warn),
    .level     (fifo_level),
    .thresh    (thr_q),
    .flags_d   (flags_d),
    .flags_q   (flags_q)
  );

  aps_port_en u_pen (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .wr_en_bit (reg_wdata[PEN_BIT]),
    .sr_q      (sr_q),
    .frame_end (frame_end),
    .active_q  (active_q)
  );

  aps_irq_out u_out (
    .clk      (clk),
    .rst      (rst),
    .flags_d  (flags_d),
    .ien_d    (ien_d),
    .req_en_d (req_d),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  always_comb begin
    reg_rdata                          = '0;
    reg_rdata[IEN_LSB +: NFLAG]        = ien_q;
    reg_rdata[REQ_BIT]                 = req_q;
    reg_rdata[THR_MSB:THR_LSB]         = thr_q;
    reg_rdata[FLAG_LSB +: NFLAG]       = flags_q;
    reg_rdata[SRST_BIT]                = sr_q;
    reg_rdata[PEN_BIT]                 = active_q;
  end

  assign fifo_clr = fclr_q;
  assign xfer_rst = sr_q;
  assign port_en  = active_q;

  assert_irq_matches_R10 : assert property (@(posedge clk) disable iff (rst)
    irq == |(flags_q & ien_q));
  assert_sreset_holds_R7 : assert property (@(posedge clk) disable iff (rst)
    sr_q |=> (flags_q[NSTICKY-1:0] == '0 && !active_q));
  assert_clr_pulse_R6 : assert property (@(posedge clk) disable iff (rst)
    fifo_clr |-> $past(reg_wr && reg_wdata[FRST_BIT]));
endmodule

// File: tb/sim_aud_port_csr.sv
module sim_aud_port_csr;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic ev_ws = 1'b0, ev_se = 1'b0, ev_fe = 1'b0, fifo_warn = 1'b0, frame_end = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [31:0] rdata, rdata_rx;
  logic irq, dma_req, fifo_clr, xfer_rst, port_en;
  logic irq1, dma1, fclr1, xrst1, pen1;

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_port_csr #(.LVL_W(LVL_W), .IS_TX(1'b1)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .ev_word_start(ev_ws), .ev_sync_err(ev_se), .ev_fifo_err(ev_fe), .fifo_warn(fifo_warn),
    .fifo_level(fifo_level), .frame_end(frame_end), .irq(irq), .dma_req(dma_req),
    .fifo_clr(fifo_clr), .xfer_rst(xfer_rst), .port_en(port_en));

  aud_port_csr #(.LVL_W(LVL_W), .IS_TX(1'b0)) u1 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_rx),
    .ev_word_start(ev_ws), .ev_sync_err(ev_se), .ev_fifo_err(ev_fe), .fifo_warn(fifo_warn),
    .fifo_level(fifo_level), .frame_end(frame_end), .irq(irq1), .dma_req(dma1),
    .fifo_clr(fclr1), .xfer_rst(xrst1), .port_en(pen1));

  // behavioural reference state
  bit [4:0] m_ien = 0;
  bit [2:0] m_st = 0;
  bit m_req = 0, m_sr = 0, m_warn = 0, m_wm = 0, m_wmrx = 0;
  bit m_enreq = 0, m_act = 0, m_fclr = 0, m_irq = 0, m_dma = 0;
  int m_thr = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ien = 0; m_st = 0; m_req = 0; m_sr = 0; m_warn = 0; m_wm = 0; m_wmrx = 0;
      m_enreq = 0; m_act = 0; m_fclr = 0; m_irq = 0; m_dma = 0; m_thr = 0;
    end else begin
      bit [2:0] ev;
      bit [2:0] st_n;
      bit enreq_n, act_n;
      ev = {ev_fe, ev_se, ev_ws};
      for (int i = 0; i < 3; i++)
        st_n[i] = m_sr ? 1'b0 : (ev[i] | (m_st[i] & !(reg_wr && reg_wdata[16+i])));
      m_wm   = (int'(fifo_level) <= m_thr);
      m_wmrx = (int'(fifo_level) > m_thr);
      m_warn = fifo_warn;
      enreq_n = m_enreq; act_n = m_act;
      if (m_sr) begin
        enreq_n = 0; act_n = 0;
      end else begin
        if (reg_wr) enreq_n = reg_wdata[31];
        if (reg_wr && reg_wdata[31]) act_n = 1;
        else if (frame_end && !enreq_n) act_n = 0;
      end
      m_st = st_n; m_enreq = enreq_n; m_act = act_n;
      m_fclr = reg_wr && reg_wdata[24];
      if (reg_wr) begin
        m_ien = reg_wdata[4:0]; m_req = reg_wdata[8];
        m_thr = int'(reg_wdata[13:9]); m_sr = reg_wdata[25];
      end
      m_irq = |({m_wm, m_warn, m_st} & m_ien);
      m_dma = m_wm & m_req;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1", "enables", rdata[4:0], m_ien);
      chk("R1", "unused bits", {rdata[30:26], rdata[23:21], rdata[15:14], rdata[7:5]}, 0);
      chk("R2 R3", "sticky flags", rdata[18:16], m_st);
      chk("R4", "warning flag", rdata[19], m_warn);
      chk("R5", "tx watermark", rdata[20], m_wm);
      chk("R5", "rx watermark", rdata_rx[20], m_wmrx);
      chk("R5", "threshold", rdata[13:9], m_thr);
      chk("R6", "fifo_clr", fifo_clr, m_fclr);
      chk("R6", "clear bit readback", rdata[24], 0);
      chk("R7", "soft reset bit", rdata[25], m_sr);
      chk("R7", "xfer_rst", xfer_rst, m_sr);
      chk("R8", "port_en", port_en, m_act);
      chk("R8", "enable readback", rdata[31], m_act);
      chk("R9", "request enable", rdata[8], m_req);
      chk("R9", "dma_req", dma_req, m_dma);
      chk("R10", "irq", irq, m_irq);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reg_wr = 0; ev_ws = 0; ev_se = 0; ev_fe = 0; frame_end = 0;
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
  endtask

  localparam logic [31:0] CFG = (32'd1 << 31) | (32'd8 << 9) | (32'd1 << 8) | 32'h1f;

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    tick(3);
    rst = 0;
    // R11 reset state
    #1;
    chk("R11", "reset readback", rdata, 0);
    chk("R11", "reset outputs", {irq, dma_req, fifo_clr, xfer_rst, port_en}, 0);
    cmp_on = 1;
    tick(1);
    wr(CFG); tick(2);                                // R1 R8 R9 configure and enable
    ev_ws = 1; tick(1); ev_se = 1; tick(1); ev_fe = 1; tick(2);   // R2
    wr(CFG | (32'd1 << 16)); tick(2);                // R2 clear word start
    wr(CFG | (32'd1 << 17)); ev_se = 1; tick(2);     // R3 collision
    wr(CFG); tick(2);                                // R2 zero writes no effect
    wr(CFG | (32'h3 << 19)); fifo_warn = 1; tick(2); // R4 R5 writes ignored
    for (int l = 0; l < 32; l++) begin               // R5 sweep level
      fifo_level = l[4:0]; fifo_warn = l[1]; tick(1);
    end
    fifo_level = 2;
    wr(CFG & ~(32'd1 << 8)); tick(2);                // R9 request enable off, port stays
    wr(CFG & ~(32'd1 << 31)); tick(4);               // R8 disable pending
    frame_end = 1; tick(3);
    wr(CFG); tick(2);
    wr(CFG & ~(32'd1 << 31)); frame_end = 1; tick(2); // R8 same-cycle end
    wr(CFG | (32'd1 << 24)); tick(3);                // R6
    ev_ws = 1; ev_fe = 1; tick(1);
    wr(CFG | (32'd1 << 25)); ev_se = 1; tick(1);     // R7
    ev_ws = 1; tick(1); ev_fe = 1; frame_end = 1; tick(2);
    wr(CFG); tick(2);
    ev_se = 1; tick(1); wr(CFG & ~32'h1f); tick(2);  // R10 enables off
    lf = 16'hACE1;
    for (int c = 0; c < 600; c++) begin              // mixed traffic
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ev_ws = lf[0] & lf[3]; ev_se = lf[1] & lf[5]; ev_fe = lf[2] & lf[7];
      fifo_warn = lf[9]; fifo_level = lf[14:10]; frame_end = lf[4] & lf[6];
      if (lf[11:8] == 4'h0 || lf[11:8] == 4'h5) begin
        wr({lf[15], 5'b0, (lf[7:5] == 3'b000), lf[3], 3'b0, lf[12:8], 2'b0,
            lf[14:10], lf[1], 3'b0, lf[6:2]});
      end
      tick(1);
    end
    wr(32'h0); tick(3);
    cmp_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule